// File: doc/BRIEF.md
# I2C Start Generator with Collision Detection

This block is the Start-condition front end of an I2C master. On a start request it checks both bus lines. It then times the SDA fall and the following SCL fall with its own baud-rate down-counter, and it ends by holding both lines low, ready for an address phase handled elsewhere. The SDA and SCL outputs are open-drain controls: 0 pulls the line low and 1 releases it. The SDA and SCL inputs are the wired bus levels, and they pass through a two-flop synchronizer before any decision uses them.

Two faults are flagged as bus collisions. The first is a line already low when the request is first examined. The second is SCL falling while SDA is still released during the first timing phase. After a collision the block goes back to idle with both lines released. If another master pulls SDA low during the first phase, that is not a fault. The block pulls SDA at once and moves straight to the second phase. Both event flags are sticky until software clears them with a write strobe.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset, both line outputs are 1 (released), and start_en, done_flag and coll_flag are 0.
- R2: If the synchronized SDA or SCL is 0 when an enabled request is first examined, coll_flag sets, start_en clears and both lines stay released. From idle this is seen two cycles after the start_req pulse is sampled.
- R3: With free lines and an effective reload N, SDA is pulled low N cycles after the examination cycle. SCL is pulled low N cycles later. At that point done_flag sets and start_en clears.
- R4: SCL seen low while SDA is seen high during the first count is a collision: coll_flag sets, start_en clears, both lines are released and the block returns to idle.
- R5: SDA seen low during the first count makes the block pull SDA low on that cycle and start the second count. No collision is flagged.
- R6: SCL seen low during the second count has no effect. The Start completes on schedule.
- R7: done_flag and coll_flag stay set until a cycle with flag_clr_we=1. In that cycle, flag_clr_data bit 0 clears done_flag and bit 1 clears coll_flag. A clear bit of 0 leaves its flag alone.
- R8: If a flag is set and cleared in the same cycle, the set wins.
- R9: A reload value of 0 acts as 1, so each count phase lasts one cycle.
- R10: After completion, both lines stay low until a new start_req. The lines are then released, and after a settle of SYNC_STAGES+1 cycles the request is examined again.
- R11: Line inputs reach the decision logic through two flops. A bus change driven before clock edge k is acted on at edge k+2.
- R12: A start_req while a Start is in progress has no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Pulse that sets start_en |
| reload | input | BRG_W | Baud-rate reload value (0 acts as 1) |
| flag_clr_we | input | 1 | Write strobe for flag clearing |
| flag_clr_data | input | 2 | Bit 0 clears done_flag, bit 1 clears coll_flag |
| sda_in | input | 1 | Bus SDA level |
| scl_in | input | 1 | Bus SCL level |
| sda_drv | output | 1 | SDA open-drain control, 0 = pull low |
| scl_drv | output | 1 | SCL open-drain control, 0 = pull low |
| start_en | output | 1 | Start enable, cleared by hardware |
| done_flag | output | 1 | Sticky start-complete flag |
| coll_flag | output | 1 | Sticky bus-collision flag |

## Verification
The hardware setting of done_flag and the software clear strobe can land on the same clock edge. The bench provokes this by timing a clear of bit 0 so that the strobe is sampled on the exact edge that finishes the second count, a cycle it works out from the reload value and the restart settle delay. It then expects done_flag to rise on that edge and to stay 1 on the next cycle. A partial clear that names only the other flag must also leave done_flag untouched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CNT1   = 3'd1,
    ST_CNT2   = 3'd2,
    ST_DONE   = 3'd3,
    ST_SETTLE = 3'd4
  } st_e;

  localparam int FLAG_DONE_BIT = 0;
  localparam int FLAG_COLL_BIT = 1;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  // released bus reads as 1, so reset to the idle level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_brg.sv
module i2cs_brg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q;

  // zero reload is promoted to one so a phase never collapses
  function automatic logic [W-1:0] eff_load(input logic [W-1:0] r);
    return (r == '0) ? W'(1) : r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= eff_load(load_val);
    else if (dec && cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  assign last = (cnt_q == W'(1));

  a_r9_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));
endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
  import i2cs_pkg::*;
#(
  parameter int W          = 8,
  parameter int SETTLE_CYC = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_en,
  input  logic         sda_s,
  input  logic         scl_s,
  input  logic         cnt_last,
  input  logic [W-1:0] reload,
  output logic         load,
  output logic         dec,
  output logic [W-1:0] load_val,
  output logic         sda_drv,
  output logic         scl_drv,
  output logic         done_evt,
  output logic         coll_evt
);
  st_e  st_q, st_d;
  logic sda_low_evt;
  logic release_evt;

  always_comb begin
    st_d        = st_q;
    load        = 1'b0;
    dec         = 1'b0;
    load_val    = reload;
    sda_low_evt = 1'b0;
    release_evt = 1'b0;
    done_evt    = 1'b0;
    coll_evt    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_en) begin
        if (!sda_s || !scl_s) begin
          coll_evt = 1'b1;
        end else begin
          load = 1'b1;
          st_d = ST_CNT1;
        end
      end
      ST_CNT1: begin
        if (!scl_s && sda_s) begin
          coll_evt = 1'b1;
          st_d     = ST_IDLE;
        end else if (!sda_s || cnt_last) begin
          sda_low_evt = 1'b1;
          load        = 1'b1;
          st_d        = ST_CNT2;
        end else begin
          dec = 1'b1;
        end
      end
      ST_CNT2: begin
        if (cnt_last) begin
          done_evt = 1'b1;
          st_d     = ST_DONE;
        end else begin
          dec = 1'b1;
        end
      end
      ST_DONE: if (start_en) begin
        release_evt = 1'b1;
        load        = 1'b1;
        load_val    = W'(SETTLE_CYC);
        st_d        = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (cnt_last) st_d = ST_IDLE;
        else          dec  = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sda_drv <= 1'b1;
      scl_drv <= 1'b1;
    end else begin
      st_q <= st_d;
      if (sda_low_evt)      sda_drv <= 1'b0;
      else if (release_evt) sda_drv <= 1'b1;
      if (done_evt)         scl_drv <= 1'b0;
      else if (release_evt) scl_drv <= 1'b1;
    end
  end

  a_r2_coll_releases: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (sda_drv && scl_drv && st_q == ST_IDLE));
  a_r3_scl_after_sda: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_drv) |-> !$past(sda_drv));
  a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE) |-> (!sda_drv && !scl_drv));
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_evt && coll_evt));
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2cs_pkg::*;
#(
  parameter int BRG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [BRG_W-1:0] reload,
  input  logic             flag_clr_we,
  input  logic [1:0]       flag_clr_data,
  input  logic             sda_in,
  input  logic             scl_in,
  output logic             sda_drv,
  output logic             scl_drv,
  output logic             start_en,
  output logic             done_flag,
  output logic             coll_flag
);
  localparam int SETTLE_CYC = SYNC_STAGES + 1;

  logic [1:0]       line_s;
  logic             sda_s, scl_s;
  logic             load, dec, cnt_last;
  logic [BRG_W-1:0] load_val;
  logic             done_evt, coll_evt;
  logic             clr_done, clr_coll;

  i2cs_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );
  assign sda_s = line_s[0];
  assign scl_s = line_s[1];

  i2cs_brg #(.W(BRG_W)) u_brg (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec),
    .load_val(load_val), .last(cnt_last)
  );

  i2cs_fsm #(.W(BRG_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start_en(start_en),
    .sda_s(sda_s), .scl_s(scl_s), .cnt_last(cnt_last), .reload(reload),
    .load(load), .dec(dec), .load_val(load_val),
    .sda_drv(sda_drv), .scl_drv(scl_drv),
    .done_evt(done_evt), .coll_evt(coll_evt)
  );

  assign clr_done = flag_clr_we && flag_clr_data[FLAG_DONE_BIT];
  assign clr_coll = flag_clr_we && flag_clr_data[FLAG_COLL_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_en  <= 1'b0;
      done_flag <= 1'b0;
      coll_flag <= 1'b0;
    end else begin
      if (done_evt || coll_evt) start_en <= 1'b0;
      else if (start_req)       start_en <= 1'b1;
      if (done_evt)      done_flag <= 1'b1;
      else if (clr_done) done_flag <= 1'b0;
      if (coll_evt)      coll_flag <= 1'b1;
      else if (clr_coll) coll_flag <= 1'b0;
    end
  end

  a_r2_en_drops: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt |=> (!start_en && coll_flag));
  a_r3_en_drops_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!start_en && !scl_drv));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !clr_done) |=> done_flag);
  a_r7_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_flag && !clr_coll) |=> coll_flag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && clr_done) |=> done_flag);
endmodule

// File: tb/test_i2c_start_gen.sv
module test_i2c_start_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0;
  logic [7:0] reload = 8'd20;
  logic       flag_clr_we = 1'b0;
  logic [1:0] flag_clr_data = 2'b00;
  logic       ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic       sda_drv, scl_drv, start_en, done_flag, coll_flag;
  wire        sda_in = sda_drv & ~ext_sda_low;
  wire        scl_in = scl_drv & ~ext_scl_low;

  int cyc = 0;
  int nchk = 0, nfail = 0;

  typedef struct { int kind; int at; string req; } exp_t;  // kind 0 done, 1 coll
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_start_gen i_i2c_start_gen (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .reload(reload),
    .flag_clr_we(flag_clr_we), .flag_clr_data(flag_clr_data),
    .sda_in(sda_in), .scl_in(scl_in), .sda_drv(sda_drv), .scl_drv(scl_drv),
    .start_en(start_en), .done_flag(done_flag), .coll_flag(coll_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
    end
  endtask

  task automatic expect_evt(input int kind, input int at, input string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  // monitor: pops expected flag events as the design raises them
  task automatic take(input int kind);
    exp_t e;
    if (q.size() == 0) begin
      chk(1'b0, "unexpected flag event", kind, -1);
    end else begin
      e = q.pop_front();
      chk(e.kind == kind, e.req, kind, e.kind);
      chk(e.at == cyc, e.req, cyc, e.at);
    end
  endtask

  logic pd = 1'b0, pc = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_flag && !pd) take(0);
      if (coll_flag && !pc) take(1);
    end
    pd = done_flag;
    pc = coll_flag;
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic kick(output int c);
    c = cyc;
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic clear(input logic [1:0] d);
    flag_clr_we = 1'b1;
    flag_clr_data = d;
    @(negedge clk);
    flag_clr_we = 1'b0;
    flag_clr_data = 2'b00;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int c, b, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sda_drv && scl_drv, "R1 lines released", {sda_drv, scl_drv}, 3);
    chk(!start_en && !done_flag && !coll_flag, "R1 flags clear",
        {start_en, done_flag, coll_flag}, 0);

    // R3 normal start from idle: b is the examination offset
    n = 20; b = 1;
    kick(c);
    expect_evt(0, c + 1 + b + 2*n, "R3 done timing");
    wait_to(c + b + n);
    chk(sda_drv, "R3 sda still released", sda_drv, 1);
    wait_to(c + 1 + b + n);
    chk(!sda_drv && scl_drv, "R3 sda low, scl high", {sda_drv, scl_drv}, 1);
    wait_to(c + b + 2*n);
    chk(scl_drv, "R3 scl high before end", scl_drv, 1);
    wait_to(c + 1 + b + 2*n);
    chk(!scl_drv && !start_en && done_flag, "R3 completion",
        {scl_drv, start_en, done_flag}, 1);

    // R7 sticky, partial clear, then real clear
    repeat (10) @(negedge clk);
    chk(done_flag, "R7 done sticky", done_flag, 1);
    clear(2'b10);
    chk(done_flag, "R7 other bit leaves done", done_flag, 1);
    clear(2'b01);
    chk(!done_flag, "R7 done cleared", done_flag, 0);
    // R10 lines held low in done state
    chk(!sda_drv && !scl_drv, "R10 held low", {sda_drv, scl_drv}, 0);

    // R10 restart from done
    b = 5;
    kick(c);
    expect_evt(0, c + 1 + b + 2*n, "R10 restart done timing");
    wait_to(c + 2);
    chk(sda_drv && scl_drv, "R10 released on restart", {sda_drv, scl_drv}, 3);
    wait_to(c + 1 + b + 2*n);
    chk(done_flag, "R10 restart completes", done_flag, 1);
    clear(2'b01);

    // R2 SDA low at outset (from done, via settle)
    ext_sda_low = 1'b1;
    kick(c);
    expect_evt(1, c + 1 + b, "R2 sda low at outset");
    wait_to(c + 2 + b);
    chk(sda_drv && scl_drv && !start_en, "R2 released, en clear",
        {sda_drv, scl_drv, start_en}, 7);
    ext_sda_low = 1'b0;
    repeat (4) @(negedge clk);
    clear(2'b10);
    chk(!coll_flag, "R7 coll cleared", coll_flag, 0);

    // R2 SCL low at outset from idle
    b = 1;
    ext_scl_low = 1'b1;
    repeat (4) @(negedge clk);
    kick(c);
    expect_evt(1, c + 1 + b, "R2 scl low at outset");
    wait_to(c + 2 + b);
    ext_scl_low = 1'b0;
    repeat (4) @(negedge clk);
    clear(2'b10);

    // R4 and R11 SCL collision in first count
    kick(c);
    expect_evt(1, c + 8, "R4 R11 scl collision timing");
    wait_to(c + 5);
    ext_scl_low = 1'b1;
    wait_to(c + 8);
    chk(sda_drv && scl_drv && !start_en, "R4 aborted and released",
        {sda_drv, scl_drv, start_en}, 7);
    ext_scl_low = 1'b0;
    repeat (4) @(negedge clk);
    clear(2'b10);

    // R5 and R11 early SDA from another master
    kick(c);
    expect_evt(0, c + 8 + n, "R5 early sda done timing");
    wait_to(c + 5);
    ext_sda_low = 1'b1;
    wait_to(c + 7);
    chk(sda_drv, "R11 sda not yet driven", sda_drv, 1);
    wait_to(c + 8);
    chk(!sda_drv && !coll_flag, "R5 sda driven early, no collision",
        {sda_drv, coll_flag}, 0);
    wait_to(c + 8 + n);
    ext_sda_low = 1'b0;
    clear(2'b01);

    // R6 SCL low during second count ignored
    b = 5;
    kick(c);
    expect_evt(0, c + 1 + b + 2*n, "R6 done despite scl low");
    wait_to(c + b + n + 3);
    ext_scl_low = 1'b1;
    wait_to(c + 1 + b + 2*n);
    chk(!coll_flag, "R6 no collision", coll_flag, 0);
    ext_scl_low = 1'b0;
    clear(2'b01);

    // R8 set and clear on the same edge
    kick(c);
    wait_to(c + b + 2*n);
    expect_evt(0, c + 1 + b + 2*n, "R8 set on clear edge");
    clear(2'b01);
    chk(done_flag, "R8 set wins", done_flag, 1);
    @(negedge clk);
    chk(done_flag, "R8 still set", done_flag, 1);
    clear(2'b01);

    // R9 reload zero acts as one
    reload = 8'd0;
    kick(c);
    expect_evt(0, c + 1 + b + 2, "R9 reload zero done timing");
    wait_to(c + 1 + b);
    chk(sda_drv, "R9 sda before count", sda_drv, 1);
    wait_to(c + 2 + b);
    chk(!sda_drv, "R9 sda after one cycle", sda_drv, 0);
    wait_to(c + 3 + b);
    clear(2'b01);
    reload = 8'd20;

    // R12 start request while busy
    kick(c);
    expect_evt(0, c + 1 + b + 2*n, "R12 timing unchanged");
    wait_to(c + b + 4);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    wait_to(c + 2 + b + 2*n);
    chk(!start_en && !scl_drv, "R12 ends in done", {start_en, scl_drv}, 0);
    clear(2'b01);

    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R3 all events seen", q.size(), 0);
    finish_run();
  end
endmodule